// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block folds a wide field of level-sensitive interrupt sources into a smaller set of group request lines. Sources are arranged in groups of eight. Each group keeps an 8-bit pending byte that tracks its eight input levels and an 8-bit enable mask. The group's request line is high whenever at least one source is both pending and enabled. A downstream interrupt controller then takes one line per group instead of one line per source.

Software reaches the block through a 32-bit register port with a single-cycle handshake. Every four groups share a 16-byte window of four registers, and each group owns one byte lane in each register. In that window, software can set enable bits, clear enable bits, read the raw pending bytes and read the enabled-and-pending bytes. Two summary words after the last window report the request line of every group as one bit per group. Writes that cannot change anything raise a one-cycle error pulse. A parameter selects an external variant, in which groups at or above a configured limit never become pending.

Top module: `grp_irq_combiner`

## Requirements
- R1: The pending byte of group g follows the levels of inputs 8g to 8g+7, registered once per clock. Input n lands in group n>>3, bit n&7. Clearing an input clears its pending bit.
- R2: Request line g is high exactly when the enable mask and the pending byte of group g share a set bit. The line updates one cycle after the mask or pending byte changes, so it updates two clock edges after an input changes.
- R3: A write to register offset 0x0 of window q (address 16q) ORs byte lane k of the data into the mask of group 4q+k. Zero bits leave mask bits unchanged.
- R4: A write to offset 0x4 of window q clears every mask bit of group 4q+k that has a 1 in lane k. Pending bytes are not affected.
- R5: A read of offset 0xC of window q returns, in lane k, the AND of the mask and pending byte of group 4q+k.
- R6: A read of offset 0x8 of window q returns the raw pending byte of group 4q+k in lane k, with lane k at data bits 8k+7 to 8k.
- R7: With 64 groups, reads of 0x100 and 0x104 return the request lines of groups 0–31 and 32–63. Bit g mod 32 of the word holds group g.
- R8: A write to offset 0x8 or 0xC of any window, or to any address at or above 0x100, raises regErr for exactly the next cycle and changes no mask. Legal writes and all reads leave regErr low.
- R9: Reads at 0x108 and above, and reads of offsets 0x0 and 0x4 of a window, return zero.
- R10: After reset, every mask and pending byte is zero and all request lines are low.
- R11: When IS_EXTERNAL is 1, inputs of groups at or above EXT_GROUP_LIMIT never set pending bits, and those groups' request lines stay low.
- R12: Read data is presented on regRdata in the cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| srcIn | input | 512 | Synchronized level inputs, bit 8g+b is source b of group g |
| regValid | input | 1 | Register access request this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 9 | Byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after a read |
| regErr | output | 1 | One-cycle pulse after an illegal write |
| grpOut | output | 64 | Group request lines |

## Verification
An enable-set write and a rising source input can land on the same clock edge for the same group. The mask and pending byte then both change at once. The bench drives both in one cycle and checks the request line at each edge: it must still be low one edge later and high two edges later. In the other direction, an illegal write lands in the same region as legal state. After each illegal write, the masked-status read must return the value it held before the write.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  typedef enum logic [2:0] {
    CMB_NOP,
    CMB_SET,
    CMB_CLR,
    CMB_RD_PEND,
    CMB_RD_MASK,
    CMB_RD_SUM,
    CMB_RD_ZERO
  } cmbOpE;

  typedef struct packed {
    cmbOpE op;
    logic  illegal;
  } cmbStrobeT;
endpackage

// File: rtl/cmb_ctrl.sv
module cmb_ctrl
  import cmb_pkg::*;
#(
  parameter int NUM_GROUPS = 64,
  parameter int LANES      = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 9,
  parameter int SEL_W      = ADDR_W - 2
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output cmbStrobeT         strobe,
  output logic [SEL_W-1:0]  selIdx
);
  localparam int NUM_QUADS = NUM_GROUPS / LANES;
  localparam int SUM_WORDS = (NUM_GROUPS + DATA_W - 1) / DATA_W;
  localparam int QUAD_W    = ADDR_W - 4;

  logic [QUAD_W-1:0] quad;
  logic [1:0]        regSel;
  logic [SEL_W-1:0]  sumIdx;

  assign quad   = regAddr[ADDR_W-1:4];
  assign regSel = regAddr[3:2];
  assign sumIdx = regAddr[ADDR_W-1:2] - SEL_W'(NUM_QUADS * 4);

  always_comb begin
    strobe.op      = CMB_NOP;
    strobe.illegal = 1'b0;
    selIdx         = '0;
    if (regValid) begin
      if (int'(quad) < NUM_QUADS) begin
        selIdx = SEL_W'(quad);
        unique case (regSel)
          2'd0: strobe.op = regWrite ? CMB_SET : CMB_RD_ZERO;
          2'd1: strobe.op = regWrite ? CMB_CLR : CMB_RD_ZERO;
          2'd2: if (regWrite) strobe.illegal = 1'b1; else strobe.op = CMB_RD_PEND;
          default: if (regWrite) strobe.illegal = 1'b1; else strobe.op = CMB_RD_MASK;
        endcase
      end else if (regWrite) begin
        strobe.illegal = 1'b1;
      end else if (int'(sumIdx) < SUM_WORDS) begin
        strobe.op = CMB_RD_SUM;
        selIdx    = sumIdx;
      end else begin
        strobe.op = CMB_RD_ZERO;
      end
    end
  end
endmodule

// File: rtl/cmb_datapath.sv
module cmb_datapath
  import cmb_pkg::*;
#(
  parameter int NUM_GROUPS      = 64,
  parameter int SRC_PER_GROUP   = 8,
  parameter int DATA_W          = 32,
  parameter int SEL_W           = 7,
  parameter bit IS_EXTERNAL     = 1'b0,
  parameter int EXT_GROUP_LIMIT = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0] srcIn,
  input  cmbStrobeT                         strobe,
  input  logic [SEL_W-1:0]                  selIdx,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output logic                              err,
  output logic [NUM_GROUPS-1:0]             grpOut
);
  localparam int LANES     = DATA_W / SRC_PER_GROUP;
  localparam int SUM_WORDS = (NUM_GROUPS + DATA_W - 1) / DATA_W;

  logic [SRC_PER_GROUP-1:0] pendR [NUM_GROUPS];
  logic [SRC_PER_GROUP-1:0] maskR [NUM_GROUPS];
  logic [SUM_WORDS*DATA_W-1:0] sumVec;
  logic [DATA_W-1:0] rdNext;
  logic rdEn;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int QUAD = g / LANES;
    localparam int LANE = g % LANES;
    logic hit;
    logic outR;
    logic [SRC_PER_GROUP-1:0] srcSlice;

    assign hit = (int'(selIdx) == QUAD);

    if (IS_EXTERNAL && g >= EXT_GROUP_LIMIT) begin : g_blocked
      assign srcSlice = '0;
    end else begin : g_open
      assign srcSlice = srcIn[g*SRC_PER_GROUP +: SRC_PER_GROUP];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendR[g] <= '0;
        maskR[g] <= '0;
        outR     <= 1'b0;
      end else begin
        pendR[g] <= srcSlice;
        if (hit && strobe.op == CMB_SET)
          maskR[g] <= maskR[g] | wdata[LANE*SRC_PER_GROUP +: SRC_PER_GROUP];
        else if (hit && strobe.op == CMB_CLR)
          maskR[g] <= maskR[g] & ~wdata[LANE*SRC_PER_GROUP +: SRC_PER_GROUP];
        outR <= |(maskR[g] & pendR[g]);
      end
    end

    assign grpOut[g] = outR;
  end

  assign sumVec = {{(SUM_WORDS*DATA_W-NUM_GROUPS){1'b0}}, grpOut};

  always_comb begin
    rdNext = '0;
    unique case (strobe.op)
      CMB_RD_PEND, CMB_RD_MASK: begin
        for (int k = 0; k < LANES; k++) begin
          if (int'(selIdx) * LANES + k < NUM_GROUPS) begin
            if (strobe.op == CMB_RD_PEND)
              rdNext[k*SRC_PER_GROUP +: SRC_PER_GROUP] = pendR[int'(selIdx)*LANES+k];
            else
              rdNext[k*SRC_PER_GROUP +: SRC_PER_GROUP] =
                pendR[int'(selIdx)*LANES+k] & maskR[int'(selIdx)*LANES+k];
          end
        end
      end
      CMB_RD_SUM: begin
        for (int w = 0; w < SUM_WORDS; w++)
          if (int'(selIdx) == w) rdNext = sumVec[w*DATA_W +: DATA_W];
      end
      default: rdNext = '0;
    endcase
  end

  assign rdEn = (strobe.op == CMB_RD_PEND) || (strobe.op == CMB_RD_MASK) ||
                (strobe.op == CMB_RD_SUM)  || (strobe.op == CMB_RD_ZERO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (rdEn) rdata <= rdNext;
      err <= strobe.illegal;
    end
  end
endmodule

// File: rtl/grp_irq_combiner.sv
module grp_irq_combiner
  import cmb_pkg::*;
#(
  parameter int NUM_GROUPS      = 64,
  parameter int SRC_PER_GROUP   = 8,
  parameter int DATA_W          = 32,
  parameter int ADDR_W          = 9,
  parameter bit IS_EXTERNAL     = 1'b0,
  parameter int EXT_GROUP_LIMIT = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0] srcIn,
  input  logic                                regValid,
  input  logic                                regWrite,
  input  logic [ADDR_W-1:0]                   regAddr,
  input  logic [DATA_W-1:0]                   regWdata,
  output logic [DATA_W-1:0]                   regRdata,
  output logic                                regErr,
  output logic [NUM_GROUPS-1:0]               grpOut
);
  localparam int LANES = DATA_W / SRC_PER_GROUP;
  localparam int SEL_W = ADDR_W - 2;

  cmbStrobeT        strobe;
  logic [SEL_W-1:0] selIdx;

  cmb_ctrl #(
    .NUM_GROUPS(NUM_GROUPS), .LANES(LANES), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_ctrl (
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .strobe(strobe), .selIdx(selIdx)
  );

  cmb_datapath #(
    .NUM_GROUPS(NUM_GROUPS), .SRC_PER_GROUP(SRC_PER_GROUP), .DATA_W(DATA_W),
    .SEL_W(SEL_W), .IS_EXTERNAL(IS_EXTERNAL), .EXT_GROUP_LIMIT(EXT_GROUP_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .strobe(strobe), .selIdx(selIdx),
    .wdata(regWdata), .rdata(regRdata), .err(regErr), .grpOut(grpOut)
  );
endmodule

// File: rtl/cmb_checker.sv
module cmb_checker #(
  parameter int NUM_GROUPS    = 64,
  parameter int SRC_PER_GROUP = 8,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 9
) (
  input logic                                clk,
  input logic                                rstN,
  input logic [NUM_GROUPS*SRC_PER_GROUP-1:0] srcIn,
  input logic                                regValid,
  input logic                                regWrite,
  input logic [ADDR_W-1:0]                   regAddr,
  input logic [DATA_W-1:0]                   regRdata,
  input logic                                regErr,
  input logic [NUM_GROUPS-1:0]               grpOut
);
  localparam int LANES    = DATA_W / SRC_PER_GROUP;
  localparam int SUM_BASE = (NUM_GROUPS / LANES) * 16;

  logic [NUM_GROUPS*SRC_PER_GROUP-1:0] srcD1, srcD2;
  logic [NUM_GROUPS-1:0] anyD2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcD1 <= '0;
      srcD2 <= '0;
    end else begin
      srcD1 <= srcIn;
      srcD2 <= srcD1;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_any
    assign anyD2[g] = |srcD2[g*SRC_PER_GROUP +: SRC_PER_GROUP];
  end

  // R2: a request line can only be high if a source of that group was high two edges back
  p_out_needs_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    (grpOut & ~anyD2) == '0);

  // R10: first cycle out of reset shows quiet outputs
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (grpOut == '0 && !regErr));

  // R8: error pulse only follows a write
  p_err_after_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    regErr |-> $past(regValid && regWrite));

  // R8: write to the pending-status register is flagged
  p_pend_write_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && int'(regAddr) < SUM_BASE && regAddr[3:2] == 2'd2) |=> regErr);

  // R8: reads never flag
  p_read_no_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite) |=> !regErr);

  // R7: first summary word mirrors request lines of the request cycle
  p_summary_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && int'(regAddr) == SUM_BASE) |=> regRdata == $past(grpOut[DATA_W-1:0]));
endmodule

bind grp_irq_combiner cmb_checker #(
  .NUM_GROUPS(NUM_GROUPS), .SRC_PER_GROUP(SRC_PER_GROUP),
  .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .srcIn(srcIn), .regValid(regValid), .regWrite(regWrite),
  .regAddr(regAddr), .regRdata(regRdata), .regErr(regErr), .grpOut(grpOut)
);

// File: tb/grp_irq_combiner_tb.sv
`timescale 1ns/1ps
module grp_irq_combiner_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [511:0] srcIn = '0;
  logic [511:0] srcInExt = '0;
  logic regValid = 1'b0;
  logic regWrite = 1'b0;
  logic [8:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata, regRdataExt;
  logic regErr, regErrExt;
  logic [63:0] grpOut, grpOutExt;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  grp_irq_combiner u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .regErr(regErr),
    .grpOut(grpOut)
  );

  grp_irq_combiner #(.IS_EXTERNAL(1'b1), .EXT_GROUP_LIMIT(16)) u_dutExt (
    .clk(clk), .rstN(rstN), .srcIn(srcInExt), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdataExt), .regErr(regErrExt),
    .grpOut(grpOutExt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWr(input logic [8:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    e = regErr;
  endtask

  task automatic regRd(input logic [8:0] a, output logic [31:0] d, output logic [31:0] dExt);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
    d = regRdata;
    dExt = regRdataExt;
  endtask

  task automatic t_reset();
    logic [31:0] d, dx;
    chk("R10 outputs low", grpOut[31:0] | grpOut[63:32], 32'h0);
    chk("R10 no error", {31'b0, regErr}, 32'h0);
    regRd(9'h008, d, dx);
    chk("R10 pending zero", d, 32'h0);
  endtask

  task automatic t_pending();
    logic [31:0] d, dx;
    srcIn[43] = 1'b1; srcIn[511] = 1'b1;
    idle(2);
    regRd(9'h018, d, dx);
    chk("R1 R6 input 43 -> group5 bit3 lane1", d, 32'h0000_0800);
    regRd(9'h0F8, d, dx);
    chk("R6 input 511 -> group63 lane3", d, 32'h8000_0000);
    chk("R2 no mask no output", grpOut[31:0] | grpOut[63:32], 32'h0);
    srcIn[43] = 1'b0; srcIn[511] = 1'b0;
    idle(2);
    regRd(9'h018, d, dx);
    chk("R1 pending clears with level", d, 32'h0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    srcIn[43] = 1'b1;
    regValid = 1'b1; regWrite = 1'b1; regAddr = 9'h010; regWdata = 32'h0000_0800;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    chk("R2 R3 one edge after enable+source", {31'b0, grpOut[5]}, 32'h0);
    @(negedge clk);
    chk("R2 R3 two edges after enable+source", {31'b0, grpOut[5]}, 32'h1);
  endtask

  task automatic t_set_masked();
    logic [31:0] d, dx;
    logic e;
    regWr(9'h010, 32'h0, e);
    idle(1);
    chk("R3 zero bits keep mask", {31'b0, grpOut[5]}, 32'h1);
    regWr(9'h010, 32'h0000_0100, e);
    srcIn[40] = 1'b1; srcIn[32] = 1'b1;
    idle(2);
    regRd(9'h01C, d, dx);
    chk("R5 masked read quad1", d, 32'h0000_0900);
    regRd(9'h018, d, dx);
    chk("R6 raw pending quad1", d, 32'h0000_0901);
    chk("R2 unmasked group4 stays low", {31'b0, grpOut[4]}, 32'h0);
    regRd(9'h010, d, dx);
    chk("R9 enable register reads zero", d, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] d, dx;
    logic e;
    regWr(9'h014, 32'h0000_0800, e);
    regRd(9'h01C, d, dx);
    chk("R4 clear bit3 leaves bit0", d, 32'h0000_0100);
    chk("R4 group5 still active", {31'b0, grpOut[5]}, 32'h1);
    regWr(9'h014, 32'h0000_0100, e);
    idle(1);
    chk("R4 group5 low after clears", {31'b0, grpOut[5]}, 32'h0);
    regRd(9'h018, d, dx);
    chk("R4 pending untouched", d, 32'h0000_0901);
  endtask

  task automatic t_summary();
    logic [31:0] d, dx;
    logic e;
    regWr(9'h0A0, 32'h0000_0001, e);
    regWr(9'h010, 32'h0000_0800, e);
    srcIn[320] = 1'b1;
    idle(3);
    chk("R2 group40 active", {31'b0, grpOut[40]}, 32'h1);
    regRd(9'h100, d, dx);
    chk("R7 R12 summary low word", d, 32'h0000_0020);
    regRd(9'h104, d, dx);
    chk("R7 summary high word", d, 32'h0000_0100);
  endtask

  task automatic t_illegal();
    logic [31:0] d, dx;
    logic e;
    regWr(9'h018, 32'hFFFF_FFFF, e);
    chk("R8 write to pending reg flags", {31'b0, e}, 32'h1);
    @(negedge clk);
    chk("R8 pulse lasts one cycle", {31'b0, regErr}, 32'h0);
    regWr(9'h01C, 32'hFFFF_FFFF, e);
    chk("R8 write to masked reg flags", {31'b0, e}, 32'h1);
    regWr(9'h100, 32'hFFFF_FFFF, e);
    chk("R8 write to summary flags", {31'b0, e}, 32'h1);
    regWr(9'h1FC, 32'hFFFF_FFFF, e);
    chk("R8 write past region flags", {31'b0, e}, 32'h1);
    regRd(9'h01C, d, dx);
    chk("R8 mask unchanged by illegal writes", d, 32'h0000_0800);
    regWr(9'h014, 32'h0, e);
    chk("R8 legal write no flag", {31'b0, e}, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d, dx;
    regRd(9'h108, d, dx);
    chk("R9 read 0x108 zero", d, 32'h0);
    chk("R9 read no flag", {31'b0, regErr}, 32'h0);
    regRd(9'h1F0, d, dx);
    chk("R9 read 0x1F0 zero", d, 32'h0);
  endtask

  task automatic t_external();
    logic [31:0] d, dx;
    logic e;
    srcInExt[24] = 1'b1; srcInExt[160] = 1'b1;
    regWr(9'h000, 32'h0100_0000, e);
    regWr(9'h050, 32'h0000_0001, e);
    idle(3);
    chk("R11 group3 active in external", {31'b0, grpOutExt[3]}, 32'h1);
    chk("R11 group20 blocked", {31'b0, grpOutExt[20]}, 32'h0);
    regRd(9'h058, d, dx);
    chk("R11 blocked group pending zero", dx, 32'h0);
    regRd(9'h008, d, dx);
    chk("R11 allowed group pending", dx, 32'h0100_0000);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_pending();
    t_same_cycle();
    t_set_masked();
    t_clear();
    t_summary();
    t_illegal();
    t_unmapped();
    t_external();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule